// File: doc/BRIEF.md
# Transfer Descriptor Completion and Interrupt Accumulator

This block evaluates one completed USB transfer descriptor and turns the result into an updated control/status word. It also says whether the owning queue head may advance, and it contributes interrupt reasons to a per-frame accumulator. The caller presents the descriptor's control/status word together with two fields taken from its token word: the encoded maximum length and the packet identifier. The caller also presents the number of bytes actually moved and a two-bit outcome code from the packet engine. The updated word and the advance flag appear one cycle later, qualified by a valid strobe.

Interrupt reasons raised during a frame gather in a pending mask. The frame-end strobe folds the pending mask into a sticky secondary status register and raises the interrupt-done status bit if any reason was present. A host-visible status register holds interrupt-done, transfer-error and process-error bits, each cleared by a write-one-to-clear strobe. The interrupt line combines these bits with per-source enables. A process error always drives the line.

Top module: `tdc_unit`

## Requirements
- R1: After synchronous reset, `upd_valid`, `upd_adv`, `upd_ctrl`, `sts`, `sec` and `irq` are all zero.
- R2: The maximum length is (`tok_maxf` + 1) mod 2048, so a field value of 0x7FF means zero bytes. An IN packet is short when its actual length is strictly below this value.
- R3: For a valid identifier (SETUP 0x2D, IN 0x69, OUT 0xE1 in `tok_pid`) with outcome 0 (success), the updated word has bits 23:17 cleared, so the active bit 23 is cleared. Bits 10:0 of the updated word hold `xfer_len` − 1 mod 2048, and every other bit is copied. `upd_adv` is 1 unless the packet is short (R5). All of this appears with `upd_valid` one cycle after `td_valid`.
- R4: A completion with outcome success, stall or babble whose word has interrupt-on-complete (bit 24) set adds reason bit 0.
- R5: A successful IN with short-packet detect (bit 29) set and a short length adds reason bit 1 and drives `upd_adv` to 0.
- R6: Outcome 1 (stall) sets bit 22 and outcome 3 (babble) sets bit 20. Both clear the active bit, write the length field as in R3, keep the other bits, drive `upd_adv` to 0, and set status bit 1 (transfer error) on the next cycle.
- R7: Outcome 2 (NAK) sets bit 19, leaves every other bit unchanged (the active bit included), adds no reason and drives `upd_adv` to 0.
- R8: Any other identifier returns the word unchanged, drives `upd_adv` to 0, adds no reason and sets status bit 2 (process error) on the next cycle. The process error drives `irq` whatever the enables.
- R9: On `frame_end`, the pending reasons, including any raised in that same cycle, are ORed into `sec` (bit 0 completion, bit 1 short). Status bit 0 is set if the mask was non-zero, and the pending mask restarts empty. A frame with no reasons leaves `sec` and status bit 0 unchanged.
- R10: Each `sts_clr` bit clears the matching status bit, and clearing bit 0 also empties `sec`. A set arriving in the same cycle as the clear wins.
- R11: `irq` is (sts[0] and ((sec[0] and int_en[0]) or (sec[1] and int_en[1]))) or (sts[1] and int_en[2]) or sts[2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| td_valid | input | 1 | A completed descriptor is presented this cycle |
| td_ctrl | input | 32 | Descriptor control/status word |
| tok_maxf | input | 11 | Encoded maximum-length field of the token |
| tok_pid | input | 8 | Packet identifier of the token |
| xfer_len | input | 11 | Bytes actually transferred |
| outcome | input | 2 | 0 success, 1 stall, 2 NAK, 3 babble |
| frame_end | input | 1 | End-of-frame strobe |
| sts_clr | input | 3 | Write-one-to-clear strobes for the status bits |
| int_en | input | 3 | Enables: 0 completion, 1 short packet, 2 error |
| upd_valid | output | 1 | Updated word is valid |
| upd_ctrl | output | 32 | Updated control/status word |
| upd_adv | output | 1 | Queue head may advance |
| sts | output | 3 | Status: 0 interrupt done, 1 error, 2 process error |
| sec | output | 2 | Secondary reason status |
| irq | output | 1 | Interrupt line |

## Verification
Two functions can fall in the same cycle: a descriptor that raises a reason can complete on the very cycle of the frame-end strobe, and a status clear can meet a new set. The bench drives `td_valid` and `frame_end` together with interrupt-on-complete and checks that the reason lands in the closing frame's `sec`. A following empty frame must then leave `sec` alone. The bench also pairs `frame_end` with a clear of the interrupt bit, and a stall with a clear of the error bit. In both cases the set must survive.

// File: rtl/tdc_pkg.sv
// Package: shared constants for descriptor completion.
// Assumes a 32-bit control/status word and an 11-bit length field.
package tdc_pkg;
    localparam int CTRL_W    = 32;
    localparam int LEN_W     = 11;
    localparam int PID_W     = 8;
    localparam int RSN_W     = 2;
    localparam int ST_W      = 3;

    localparam int B_SPD     = 29;
    localparam int B_IOC     = 24;
    localparam int B_ACT     = 23;
    localparam int B_STALL   = 22;
    localparam int B_BABBLE  = 20;
    localparam int B_NAK     = 19;
    localparam int B_STS_LO  = 17;

    localparam int RSN_DONE  = 0;
    localparam int RSN_SHORT = 1;

    localparam int ST_INT    = 0;
    localparam int ST_ERR    = 1;
    localparam int ST_PERR   = 2;

    localparam logic [PID_W-1:0] PID_SETUP = 8'h2D;
    localparam logic [PID_W-1:0] PID_IN    = 8'h69;
    localparam logic [PID_W-1:0] PID_OUT   = 8'hE1;

    typedef enum logic [1:0] {
        OC_OK     = 2'd0,
        OC_STALL  = 2'd1,
        OC_NAK    = 2'd2,
        OC_BABBLE = 2'd3
    } outcome_e;
endpackage

// File: rtl/tdc_len_cmp.sv
// Module: decodes the n+1 maximum length and flags a short transfer.
// Assumes the field wraps modulo 2^LEN_W (all-ones encodes zero).
module tdc_len_cmp #(
    parameter int LEN_W = 11
) (
    input  logic [LEN_W-1:0] maxf,
    input  logic [LEN_W-1:0] act_len,
    output logic [LEN_W-1:0] max_len,
    output logic             is_short
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    // Decode the maximum length and compare against the actual length.
    always_comb begin
        max_len  = maxf + ONE;
        is_short = (act_len < max_len);
    end
endmodule

// File: rtl/tdc_eval.sv
// Module: combinational evaluation of one completed descriptor.
// Produces the new control word, advance flag, reasons and error hits.
// Assumes the caller qualifies all outputs with its own valid strobe.
module tdc_eval
    import tdc_pkg::*;
#(
    parameter int CW = CTRL_W,
    parameter int LW = LEN_W
) (
    input  logic [CW-1:0]    ctrl_in,
    input  logic [LW-1:0]    maxf,
    input  logic [PID_W-1:0] pid,
    input  logic [LW-1:0]    act_len,
    input  logic [1:0]       oc,
    output logic [CW-1:0]    ctrl_out,
    output logic             adv,
    output logic [RSN_W-1:0] rsn,
    output logic             perr_hit,
    output logic             err_hit
);
    localparam logic [LW-1:0] ONE = LW'(1);

    logic [LW-1:0] max_len;
    logic          len_short;
    logic          pid_ok;
    logic          pid_in;
    logic [LW-1:0] len_field;
    outcome_e      oc_e;

    tdc_len_cmp #(.LEN_W(LW)) u_len (
        .maxf     (maxf),
        .act_len  (act_len),
        .max_len  (max_len),
        .is_short (len_short)
    );

    // Classify the packet identifier.
    always_comb begin
        pid_in = (pid == PID_IN);
        pid_ok = pid_in || (pid == PID_OUT) || (pid == PID_SETUP);
        oc_e   = outcome_e'(oc);
        len_field = act_len - ONE;
    end

    // Build the updated word, advance flag and interrupt reasons.
    always_comb begin
        ctrl_out = ctrl_in;
        adv      = 1'b0;
        rsn      = '0;
        perr_hit = 1'b0;
        err_hit  = 1'b0;
        if (!pid_ok) begin
            perr_hit = 1'b1;
        end else begin
            unique case (oc_e)
                OC_OK: begin
                    for (int b = B_STS_LO; b <= B_ACT; b++) begin
                        ctrl_out[b] = 1'b0;
                    end
                    ctrl_out[LW-1:0] = len_field;
                    rsn[RSN_DONE]    = ctrl_in[B_IOC];
                    if (pid_in && ctrl_in[B_SPD] && len_short) begin
                        rsn[RSN_SHORT] = 1'b1;
                        adv            = 1'b0;
                    end else begin
                        adv = 1'b1;
                    end
                end
                OC_STALL, OC_BABBLE: begin
                    ctrl_out[B_ACT]  = 1'b0;
                    if (oc_e == OC_STALL) ctrl_out[B_STALL]  = 1'b1;
                    else                  ctrl_out[B_BABBLE] = 1'b1;
                    ctrl_out[LW-1:0] = len_field;
                    rsn[RSN_DONE]    = ctrl_in[B_IOC];
                    err_hit          = 1'b1;
                end
                OC_NAK: begin
                    ctrl_out[B_NAK] = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tdc_irq_acc.sv
// Module: per-frame reason accumulator, status register and interrupt line.
// Reasons raised in the frame-end cycle belong to the closing frame; a set
// beats a same-cycle clear.
module tdc_irq_acc
    import tdc_pkg::*;
#(
    parameter int RW = RSN_W,
    parameter int SW = ST_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] rsn_in,
    input  logic          err_in,
    input  logic          perr_in,
    input  logic          frame_end,
    input  logic [SW-1:0] sts_clr,
    input  logic [SW-1:0] int_en,
    output logic [SW-1:0] sts,
    output logic [RW-1:0] sec,
    output logic          irq
);
    logic [RW-1:0] pend_q;
    logic [RW-1:0] fold;
    logic [RW-1:0] pend_d;
    logic [RW-1:0] sec_d;
    logic [SW-1:0] sts_set;
    logic [SW-1:0] sts_d;

    // Fold this cycle's reasons into the pending mask and compute next state.
    always_comb begin
        fold   = pend_q | rsn_in;
        pend_d = frame_end ? '0 : fold;
        sec_d  = (sts_clr[ST_INT] ? '0 : sec) | (frame_end ? fold : '0);
        sts_set          = '0;
        sts_set[ST_INT]  = frame_end && (|fold);
        sts_set[ST_ERR]  = err_in;
        sts_set[ST_PERR] = perr_in;
        sts_d = (sts & ~sts_clr) | sts_set;
    end

    // Register the pending mask, secondary status and status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            sec    <= '0;
            sts    <= '0;
        end else begin
            pend_q <= pend_d;
            sec    <= sec_d;
            sts    <= sts_d;
        end
    end

    // Combine status bits with their enables; process error is unmasked.
    always_comb begin
        irq = (sts[ST_INT] && ((sec[RSN_DONE] && int_en[0]) ||
                               (sec[RSN_SHORT] && int_en[1])))
           || (sts[ST_ERR] && int_en[2])
           || sts[ST_PERR];
    end

    p_frame_sets_int_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && (|pend_q)) |=> sts[ST_INT]);

    p_sec_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_clr[ST_INT] |=> ((sec & $past(sec)) == $past(sec)));

    p_perr_drives_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sts[ST_PERR] |-> irq);
endmodule

// File: rtl/tdc_unit.sv
// Module: top of the descriptor completion block. Registers the evaluated
// word and advance flag one cycle after td_valid and feeds the accumulator.
// Assumes one descriptor per cycle at most.
module tdc_unit
    import tdc_pkg::*;
#(
    parameter int CW = CTRL_W,
    parameter int LW = LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             td_valid,
    input  logic [CW-1:0]    td_ctrl,
    input  logic [LW-1:0]    tok_maxf,
    input  logic [PID_W-1:0] tok_pid,
    input  logic [LW-1:0]    xfer_len,
    input  logic [1:0]       outcome,
    input  logic             frame_end,
    input  logic [ST_W-1:0]  sts_clr,
    input  logic [ST_W-1:0]  int_en,
    output logic             upd_valid,
    output logic [CW-1:0]    upd_ctrl,
    output logic             upd_adv,
    output logic [ST_W-1:0]  sts,
    output logic [RSN_W-1:0] sec,
    output logic             irq
);
    logic [CW-1:0]    ev_ctrl;
    logic             ev_adv;
    logic [RSN_W-1:0] ev_rsn;
    logic             ev_perr;
    logic             ev_err;
    logic [RSN_W-1:0] g_rsn;
    logic             g_perr;
    logic             g_err;

    tdc_eval #(.CW(CW), .LW(LW)) u_eval (
        .ctrl_in  (td_ctrl),
        .maxf     (tok_maxf),
        .pid      (tok_pid),
        .act_len  (xfer_len),
        .oc       (outcome),
        .ctrl_out (ev_ctrl),
        .adv      (ev_adv),
        .rsn      (ev_rsn),
        .perr_hit (ev_perr),
        .err_hit  (ev_err)
    );

    // Qualify evaluation results with the descriptor strobe.
    always_comb begin
        g_rsn  = td_valid ? ev_rsn : '0;
        g_perr = td_valid && ev_perr;
        g_err  = td_valid && ev_err;
    end

    // Register the updated word for writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_ctrl  <= '0;
            upd_adv   <= 1'b0;
        end else begin
            upd_valid <= td_valid;
            if (td_valid) begin
                upd_ctrl <= ev_ctrl;
                upd_adv  <= ev_adv;
            end
        end
    end

    tdc_irq_acc #(.RW(RSN_W), .SW(ST_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .rsn_in    (g_rsn),
        .err_in    (g_err),
        .perr_in   (g_perr),
        .frame_end (frame_end),
        .sts_clr   (sts_clr),
        .int_en    (int_en),
        .sts       (sts),
        .sec       (sec),
        .irq       (irq)
    );

    p_nak_stays_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (td_valid && outcome == 2'd2 && tok_pid == PID_IN)
        |=> (upd_ctrl[B_ACT] == $past(td_ctrl[B_ACT]) && !upd_adv));

    p_short_no_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (td_valid && outcome == 2'd0 && tok_pid == PID_IN && td_ctrl[B_SPD]
         && (xfer_len < LW'(tok_maxf + LW'(1))))
        |=> (!upd_adv && sec == sec) );

    p_bad_pid_perr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (td_valid && tok_pid != PID_IN && tok_pid != PID_OUT && tok_pid != PID_SETUP)
        |=> (sts[ST_PERR] && !upd_adv));

    p_success_clears_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (td_valid && outcome == 2'd0 && tok_pid == PID_OUT)
        |=> (upd_valid && !upd_ctrl[B_ACT] && upd_adv));
endmodule

// File: tb/tdc_unit_bench.sv
module tdc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        td_valid = 1'b0;
    logic [31:0] td_ctrl = '0;
    logic [10:0] tok_maxf = '0;
    logic [7:0]  tok_pid = '0;
    logic [10:0] xfer_len = '0;
    logic [1:0]  outcome = '0;
    logic        frame_end = 1'b0;
    logic [2:0]  sts_clr = '0;
    logic [2:0]  int_en = '0;
    logic        upd_valid;
    logic [31:0] upd_ctrl;
    logic        upd_adv;
    logic [2:0]  sts;
    logic [1:0]  sec;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tdc_unit u_tdc_unit (
        .clk(clk), .rst_n(rst_n), .td_valid(td_valid), .td_ctrl(td_ctrl),
        .tok_maxf(tok_maxf), .tok_pid(tok_pid), .xfer_len(xfer_len),
        .outcome(outcome), .frame_end(frame_end), .sts_clr(sts_clr),
        .int_en(int_en), .upd_valid(upd_valid), .upd_ctrl(upd_ctrl),
        .upd_adv(upd_adv), .sts(sts), .sec(sec), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    task automatic clear_all;
        sts_clr = 3'b111; step; sts_clr = 3'b000;
    endtask

    task automatic put_td(input logic [31:0] c, input logic [7:0] p,
                          input logic [10:0] mf, input logic [10:0] ln,
                          input logic [1:0] oc);
        td_ctrl = c; tok_pid = p; tok_maxf = mf; xfer_len = ln; outcome = oc;
        td_valid = 1'b1;
    endtask

    // Expected model from the requirements
    task automatic model(input logic [31:0] c, input logic [7:0] p,
                         input logic [10:0] mf, input logic [10:0] ln,
                         input logic [1:0] oc, output logic [31:0] ec,
                         output bit adv, output logic [1:0] rs,
                         output bit perr, output bit err);
        logic [10:0] ml;
        bit pidok, shrt;
        ml    = mf + 11'd1;
        pidok = (p == 8'h2D) || (p == 8'h69) || (p == 8'hE1);
        shrt  = (p == 8'h69) && c[29] && (ln < ml);
        ec = c; adv = 0; rs = 0; perr = 0; err = 0;
        if (!pidok) perr = 1;
        else if (oc == 2'd0) begin
            ec = (c & ~32'h00FE_0000 & ~32'h7FF) | {21'd0, ln - 11'd1};
            adv = !shrt; rs = {shrt, c[24]};
        end else if (oc == 2'd2) begin
            ec = c | 32'h0008_0000;
        end else begin
            ec = (c & ~32'h0080_0000 & ~32'h7FF) | {21'd0, ln - 11'd1};
            ec = ec | ((oc == 2'd1) ? 32'h0040_0000 : 32'h0010_0000);
            rs = {1'b0, c[24]}; err = 1;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] ec;
        bit adv, perr, err;
        logic [1:0] rs;
        logic [7:0]  pids [4];
        logic [10:0] mfs  [4];
        logic [10:0] lens [4];
        pids = '{8'h2D, 8'h69, 8'hE1, 8'h55};
        mfs  = '{11'h000, 11'h003, 11'h03F, 11'h7FF};
        lens = '{11'd0, 11'd3, 11'd4, 11'd64};

        repeat (3) step;
        // R1 reset state
        chk(upd_valid == 0 && upd_adv == 0 && upd_ctrl == 0, "R1 upd", upd_ctrl, 0);
        chk(sts == 0 && sec == 0 && irq == 0, "R1 status", {sts, sec, irq}, 0);
        rst_n = 1'b1; step;

        // Sweep: R2 R3 R4 R5 R6 R7 R8 R9
        for (int o = 0; o < 4; o++)
        for (int pi = 0; pi < 4; pi++)
        for (int s = 0; s < 2; s++)
        for (int i = 0; i < 2; i++)
        for (int mi = 0; mi < 4; mi++)
        for (int li = 0; li < 4; li++) begin
            logic [31:0] c;
            c = 32'hD880_0000 | 32'h0014_0000 | 32'h2AA
              | (32'(s) << 29) | (32'(i) << 24);
            clear_all;
            put_td(c, pids[pi], mfs[mi], lens[li], 2'(o));
            step; td_valid = 1'b0;
            model(c, pids[pi], mfs[mi], lens[li], 2'(o), ec, adv, rs, perr, err);
            chk(upd_valid && upd_ctrl == ec, "R3 R6 R7 R8 word", upd_ctrl, ec);
            chk(upd_adv == adv, "R2 R5 advance", 32'(upd_adv), 32'(adv));
            chk(sts[2:1] == {perr, err}, "R6 R8 status", 32'(sts), {perr, err, 1'b0});
            frame_end = 1'b1; step; frame_end = 1'b0;
            chk(sec == rs, "R4 R5 R9 sec", 32'(sec), 32'(rs));
            chk(sts[0] == (|rs), "R9 int", 32'(sts), 32'(|rs));
            chk(upd_valid == 0, "R3 one-shot valid", 32'(upd_valid), 0);
        end

        // R9 collision: completion in the frame-end cycle joins closing frame
        clear_all;
        put_td(32'h0180_0000, 8'hE1, 11'd7, 11'd8, 2'd0);
        frame_end = 1'b1; step; td_valid = 1'b0; frame_end = 1'b0;
        chk(sec == 2'b01 && sts[0], "R9 same-cycle", {sts, sec}, 32'b00101);
        frame_end = 1'b1; step; frame_end = 1'b0;
        chk(sec == 2'b01 && sts[0], "R9 empty frame keeps", {sts, sec}, 32'b00101);
        sts_clr = 3'b001; step; sts_clr = 3'b000;
        chk(sec == 0 && sts[0] == 0, "R10 clear int empties sec", {sts, sec}, 0);
        frame_end = 1'b1; step; frame_end = 1'b0;
        chk(sts[0] == 0 && sec == 0, "R9 zero mask", {sts, sec}, 0);

        // R10 set wins over clear
        clear_all;
        put_td(32'h0180_0000, 8'h2D, 11'd7, 11'd8, 2'd0);
        step; td_valid = 1'b0;
        sts_clr = 3'b001; frame_end = 1'b1; step; sts_clr = 0; frame_end = 0;
        chk(sts[0] && sec == 2'b01, "R10 set beats clear int", {sts, sec}, 32'b00101);
        put_td(32'h0080_0000, 8'h69, 11'd7, 11'd8, 2'd1);
        sts_clr = 3'b010; step; td_valid = 1'b0; sts_clr = 0;
        chk(sts[1], "R10 set beats clear err", 32'(sts), 32'b011);

        // R11 enables (state: sts={0,1,1}, sec=01)
        sts_clr = 3'b010; step; sts_clr = 0;
        int_en = 3'b000; #1;
        chk(irq == 0, "R11 none", 32'(irq), 0);
        int_en = 3'b001; #1;
        chk(irq == 1, "R11 done en", 32'(irq), 1);
        int_en = 3'b010; #1;
        chk(irq == 0, "R11 short en wrong", 32'(irq), 0);
        clear_all;
        put_td(32'h2080_0000, 8'h69, 11'd63, 11'd5, 2'd0);
        step; td_valid = 1'b0;
        frame_end = 1'b1; step; frame_end = 1'b0;
        int_en = 3'b010; #1;
        chk(irq == 1 && sec == 2'b10, "R11 short en", {sec, irq}, 32'b101);
        int_en = 3'b001; #1;
        chk(irq == 0, "R11 done en wrong", 32'(irq), 0);
        clear_all;
        put_td(32'h0080_0000, 8'hE1, 11'd7, 11'd8, 2'd3);
        step; td_valid = 1'b0;
        int_en = 3'b100; #1;
        chk(irq == 1, "R11 err en", 32'(irq), 1);
        int_en = 3'b000; #1;
        chk(irq == 0, "R11 err masked", 32'(irq), 0);
        clear_all;
        put_td(32'h0080_0000, 8'h00, 11'd7, 11'd8, 2'd0);
        step; td_valid = 1'b0; #1;
        chk(irq == 1 && sts[2], "R8 perr unmasked", {sts, irq}, 32'b1001);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule